// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small word-addressed memory that pairs every word with a one-bit occupancy tag, marked either full or empty. Two requesters share it: a producer port that writes and a consumer port that reads. An access of the synchronizing kind tests the addressed word's tag and updates it in the same clock edge as the data transfer. A producer may only deposit into an empty word, which then becomes full. A consumer may only take from a full word, which then becomes empty. This gives word-granular hand-off between a producer and a consumer without a separate flag variable or a lock.

A synchronizing access whose tag condition does not hold is refused in that cycle. The port's ready output stays low, and the requester holds its request and tries again later. Both ports also offer a plain mode that moves data without looking at or touching the tag, for initialisation and debug traffic. Ready is combinational in the cycle of the request. Write data is stored at the following clock edge, and read data appears on the cycle after the read is accepted.

Top module: `fe_tagged_mem`

## Requirements
- R1: After reset every tag is empty, so a synchronizing read to any word is refused, and every word holds zero.
- R2: A synchronizing write (p_valid=1, p_sync=1) to an empty word is accepted (p_ready=1 in that cycle), stores p_wdata and marks the word full.
- R3: A synchronizing write to a full word is refused (p_ready=0) and leaves the word's data and tag unchanged.
- R4: A synchronizing read (c_valid=1, c_sync=1) of a full word is accepted (c_ready=1), returns the word on c_rdata with c_rvalid=1 one cycle later, and marks the word empty.
- R5: A synchronizing read of an empty word is refused (c_ready=0), gives c_rvalid=0 on the next cycle, and leaves the tag empty.
- R6: A plain write (p_sync=0) is always accepted, stores its data, and leaves the tag as it was, whether full or empty.
- R7: A plain read (c_sync=0) is always accepted, returns the stored word one cycle later, and leaves the tag as it was.
- R8: When both ports issue synchronizing accesses to the same word in one cycle, only the one whose condition holds on the current tag is accepted. An empty word admits the write and a full word admits the read. The other port is refused and may retry.
- R9: When a read and a write to the same word are both accepted in one cycle, the read returns the value held before that cycle's write.
- R10: With valid low, a port's ready is low and no tag or data changes. c_rvalid is high only in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_valid | input | 1 | Producer request present |
| p_sync | input | 1 | Producer mode: 1 synchronizing, 0 plain |
| p_addr | input | ADDR_W | Producer word address |
| p_wdata | input | DATA_W | Producer write data |
| p_ready | output | 1 | Producer request accepted this cycle |
| c_valid | input | 1 | Consumer request present |
| c_sync | input | 1 | Consumer mode: 1 synchronizing, 0 plain |
| c_addr | input | ADDR_W | Consumer word address |
| c_ready | output | 1 | Consumer request accepted this cycle |
| c_rvalid | output | 1 | Read data valid (one cycle after acceptance) |
| c_rdata | output | DATA_W | Read data |

## Verification
Each ready is due in the same cycle as its request. The bench drives inputs on the falling edge and samples both readies a small delay later, before the rising edge. Stored data and tag changes take effect at the next rising edge, and c_rvalid and c_rdata are sampled just after that edge. Any effect of a write on the tag is observed only through a later synchronizing request and whether it is accepted.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_PLAIN = 2'd1,
        ACC_SYNC  = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic valid, input logic sync);
        if (!valid)     return ACC_NONE;
        else if (sync)  return ACC_SYNC;
        else            return ACC_PLAIN;
    endfunction

    // Whether an access may complete given the word's current tag (1 = full).
    function automatic logic may_proceed(input acc_kind_e kind,
                                         input logic tag_full,
                                         input logic is_write);
        case (kind)
            ACC_PLAIN: return 1'b1;
            ACC_SYNC:  return is_write ? !tag_full : tag_full;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fe_access_gate.sv
module fe_access_gate
    import fe_pkg::*;
#(
    parameter bit IS_WRITE = 1'b1
) (
    input  logic rst,
    input  logic valid,
    input  logic sync,
    input  logic tag_full,
    output logic ready,
    output logic tag_flip
);
    acc_kind_e kind;

    always_comb begin
        kind     = classify(valid, sync);
        ready    = !rst && may_proceed(kind, tag_full, IS_WRITE);
        tag_flip = ready && (kind == ACC_SYNC);
    end

endmodule

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] look_a,
    input  logic [ADDR_W-1:0] look_b,
    output logic              full_a,
    output logic              full_b,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr
);
    logic [DEPTH-1:0] tag_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_tag
        always_ff @(posedge clk) begin
            if (rst)
                tag_q[i] <= 1'b0;
            else if (set_en && set_addr == ADDR_W'(i))
                tag_q[i] <= 1'b1;
            else if (clr_en && clr_addr == ADDR_W'(i))
                tag_q[i] <= 1'b0;
        end
    end

    assign full_a = tag_q[look_a];
    assign full_b = tag_q[look_b];

    AST_SET_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !tag_q[set_addr]); // R2
    AST_CLR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> tag_q[clr_addr]); // R4
    AST_SET_CLR_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        !(set_en && clr_en && set_addr == clr_addr)); // R8
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        set_en |=> tag_q[$past(set_addr)]); // R2

endmodule

// File: rtl/fe_word_store.sv
module fe_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[i] <= '0;
            else if (we && waddr == ADDR_W'(i))
                mem_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= re;
            if (re)
                rdata <= mem_q[raddr];
        end
    end

endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p_valid,
    input  logic              p_sync,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0] p_wdata,
    output logic              p_ready,
    input  logic              c_valid,
    input  logic              c_sync,
    input  logic [ADDR_W-1:0] c_addr,
    output logic              c_ready,
    output logic              c_rvalid,
    output logic [DATA_W-1:0] c_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic p_full, c_full;
    logic p_set, c_clr;

    fe_tag_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .look_a   (p_addr),
        .look_b   (c_addr),
        .full_a   (p_full),
        .full_b   (c_full),
        .set_en   (p_set),
        .set_addr (p_addr),
        .clr_en   (c_clr),
        .clr_addr (c_addr)
    );

    fe_access_gate #(.IS_WRITE(1'b1)) u_prod_gate (
        .rst      (rst),
        .valid    (p_valid),
        .sync     (p_sync),
        .tag_full (p_full),
        .ready    (p_ready),
        .tag_flip (p_set)
    );

    fe_access_gate #(.IS_WRITE(1'b0)) u_cons_gate (
        .rst      (rst),
        .valid    (c_valid),
        .sync     (c_sync),
        .tag_full (c_full),
        .ready    (c_ready),
        .tag_flip (c_clr)
    );

    fe_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (p_ready),
        .waddr  (p_addr),
        .wdata  (p_wdata),
        .re     (c_ready),
        .raddr  (c_addr),
        .rvalid (c_rvalid),
        .rdata  (c_rdata)
    );

    AST_PREADY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        p_ready |-> p_valid); // R10
    AST_CREADY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        c_ready |-> c_valid); // R10
    AST_RVALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        c_ready |=> c_rvalid); // R4
    AST_NO_RVALID_ON_REFUSE: assert property (@(posedge clk) disable iff (rst)
        !c_ready |=> !c_rvalid); // R5
    AST_SYNC_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(p_ready && p_sync && c_ready && c_sync && p_addr == c_addr)); // R8
    AST_PLAIN_ALWAYS_OK: assert property (@(posedge clk) disable iff (rst)
        (p_valid && !p_sync) |-> p_ready); // R6

endmodule

// File: tb/fe_tagged_mem_bench.sv
module fe_tagged_mem_bench;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              p_valid, p_sync, c_valid, c_sync;
    logic [ADDR_W-1:0] p_addr, c_addr;
    logic [DATA_W-1:0] p_wdata;
    logic              p_ready, c_ready, c_rvalid;
    logic [DATA_W-1:0] c_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    fe_tagged_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fe_tagged_mem (
        .clk(clk), .rst(rst),
        .p_valid(p_valid), .p_sync(p_sync), .p_addr(p_addr), .p_wdata(p_wdata),
        .p_ready(p_ready),
        .c_valid(c_valid), .c_sync(c_sync), .c_addr(c_addr),
        .c_ready(c_ready), .c_rvalid(c_rvalid), .c_rdata(c_rdata)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    // One bus cycle on both ports; readies sampled before the edge, read data after.
    task automatic step(input logic pv, input logic ps, input int pa, input int pd,
                        input logic cv, input logic cs, input int ca,
                        output logic pr, output logic cr,
                        output logic rv, output int rd);
        @(negedge clk);
        p_valid = pv; p_sync = ps; p_addr = ADDR_W'(pa); p_wdata = DATA_W'(pd);
        c_valid = cv; c_sync = cs; c_addr = ADDR_W'(ca);
        #1;
        pr = p_ready; cr = c_ready;
        @(posedge clk);
        #1;
        rv = c_rvalid; rd = int'(c_rdata);
        p_valid = 1'b0; c_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic pr, cr, rv; int rd;
        step(0, 0, 0, 0, 1, 1, 3, pr, cr, rv, rd);
        check("R1 sync read after reset refused", cr, 0);
        check("R5 no rvalid on refused read", rv, 0);
        step(0, 0, 0, 0, 1, 0, 3, pr, cr, rv, rd);
        check("R1 word zero after reset", rd, 0);
        check("R7 plain read accepted", cr & rv, 1);
    endtask

    task automatic t_sync_pair();
        logic pr, cr, rv; int rd;
        step(1, 1, 3, 'hA5A5, 0, 0, 0, pr, cr, rv, rd);
        check("R2 sync write to empty accepted", pr, 1);
        step(1, 1, 3, 'h5555, 0, 0, 0, pr, cr, rv, rd);
        check("R3 sync write to full refused", pr, 0);
        step(0, 0, 0, 0, 1, 1, 3, pr, cr, rv, rd);
        check("R4 sync read of full accepted", cr, 1);
        check("R4 rvalid next cycle", rv, 1);
        check("R3 data unchanged by refused write", rd, 'hA5A5);
        step(0, 0, 0, 0, 1, 1, 3, pr, cr, rv, rd);
        check("R4 word empty after sync read", cr, 0);
    endtask

    task automatic t_plain();
        logic pr, cr, rv; int rd;
        step(1, 0, 7, 'h1234, 0, 0, 0, pr, cr, rv, rd);
        check("R6 plain write accepted", pr, 1);
        step(0, 0, 0, 0, 1, 1, 7, pr, cr, rv, rd);
        check("R6 tag stays empty after plain write", cr, 0);
        step(0, 0, 0, 0, 1, 0, 7, pr, cr, rv, rd);
        check("R7 plain read data", rd, 'h1234);
        step(1, 1, 7, 'hBEEF, 0, 0, 0, pr, cr, rv, rd);
        step(0, 0, 0, 0, 1, 0, 7, pr, cr, rv, rd);
        check("R7 plain read of full word", rd, 'hBEEF);
        step(0, 0, 0, 0, 1, 1, 7, pr, cr, rv, rd);
        check("R7 tag stays full after plain read", cr, 1);
        step(1, 1, 9, 'h1111, 0, 0, 0, pr, cr, rv, rd);
        step(1, 0, 9, 'h2222, 0, 0, 0, pr, cr, rv, rd);
        check("R6 plain write to full word accepted", pr, 1);
        step(1, 1, 9, 'h3333, 0, 0, 0, pr, cr, rv, rd);
        check("R6 tag stays full after plain write", pr, 0);
        step(0, 0, 0, 0, 1, 1, 9, pr, cr, rv, rd);
        check("R6 plain data kept", rd, 'h2222);
    endtask

    task automatic t_conflict();
        logic pr, cr, rv; int rd;
        step(1, 1, 5, 'h0ABC, 1, 1, 5, pr, cr, rv, rd);
        check("R8 empty word admits write", pr, 1);
        check("R8 empty word refuses read", cr, 0);
        step(0, 0, 0, 0, 1, 1, 5, pr, cr, rv, rd);
        check("R8 read retry succeeds", rd, 'h0ABC);
        step(1, 1, 5, 'h0F0F, 0, 0, 0, pr, cr, rv, rd);
        step(1, 1, 5, 'h7777, 1, 1, 5, pr, cr, rv, rd);
        check("R8 full word refuses write", pr, 0);
        check("R8 full word admits read", cr, 1);
        check("R8 read data on full conflict", rd, 'h0F0F);
        step(1, 1, 5, 'h7777, 0, 0, 0, pr, cr, rv, rd);
        check("R8 write retry succeeds", pr, 1);
    endtask

    task automatic t_same_cycle();
        logic pr, cr, rv; int rd;
        step(1, 1, 2, 'h1010, 0, 0, 0, pr, cr, rv, rd);
        step(1, 0, 2, 'h2020, 1, 1, 2, pr, cr, rv, rd);
        check("R9 both accepted", pr & cr, 1);
        check("R9 read sees old value", rd, 'h1010);
        step(0, 0, 0, 0, 1, 0, 2, pr, cr, rv, rd);
        check("R9 new value stored", rd, 'h2020);
    endtask

    task automatic t_idle();
        logic pr, cr, rv; int rd;
        step(0, 1, 4, 'h4444, 0, 1, 4, pr, cr, rv, rd);
        check("R10 producer ready low when idle", pr, 0);
        check("R10 consumer ready low when idle", cr, 0);
        check("R10 no rvalid when idle", rv, 0);
        step(1, 1, 4, 'h4545, 0, 0, 0, pr, cr, rv, rd);
        check("R10 idle did not fill word", pr, 1);
    endtask

    initial begin
        rst = 1'b1;
        p_valid = 0; p_sync = 0; p_addr = '0; p_wdata = '0;
        c_valid = 0; c_sync = 0; c_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        fork
            begin
                t_reset();
                t_sync_pair();
                t_plain();
                t_conflict();
                t_same_cycle();
                t_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule